// File: doc/BRIEF.md
# System Error Interrupt Collector

This block gathers 64 error sources into one summary interrupt line. Each source has a pending bit, which lives in a cause bank, and an enable control, which lives in a mask bank. In the mask bank a 1 turns the source off. The summary line is high whenever at least one pending bit has its mask bit clear.

The sources come from two kinds of producer:
- **Wired sources 0 to 20** are active-high level inputs. Each one re-latches its pending bit on every clock cycle while its input stays high.
- **Sources 21 to 63** are set by message-style writes to a doorbell register. The data word written to the doorbell names the source to mark pending.

Software reads the pending bits and clears them by writing 1s. It writes the mask words directly. All access goes through a plain 32-bit register port with separate address, write-data, write-enable and read-data signals. Reads are combinational and writes take effect at the clock edge.

Top module: `err_irq_collector`

## Requirements
- R1: After reset every cause bit reads 0, every mask bit reads 1 and `irq_o` is low.
- R2: Source n sits in word n/32 at bit n%32. The cause words are at byte addresses 0x00 and 0x04, and the mask words are at 0x20 and 0x24. Any other address, including the doorbell at 0x30, reads as 0.
- R3: Writing a cause word clears each pending bit whose write-data bit is 1 and leaves every bit written with 0 unchanged. Cause reads return the raw pending bits, before masking.
- R4: A mask bit of 1 disables its source and 0 enables it. Mask words read back exactly as written. `irq_o` is high in the cycle after an edge that leaves some pending bit with its mask bit clear.
- R5: A write to 0x30 sets the pending bit of the source named by write-data bits [5:0]. Bits [31:6] are ignored.
- R6: A doorbell write whose index is below 21 changes no cause bit.
- R7: While wired input n (n < 21) is high, its pending bit is set at every clock edge. A clear written in the same cycle loses to the set, so the bit stays pending. Once the input is low, the bit stays pending until it is cleared.
- R8: Masking does not discard a pending event. A bit that became pending while masked raises `irq_o` as soon as it is unmasked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wired_i | input | 21 | Level inputs for sources 0..20 |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Summary interrupt |

## Verification
The bench aims at the edges of the doorbell decode:
- An index below 21 must be dropped. A decoder that skipped this check would light a wired source's bit.
- Junk in the upper data bits must be ignored. A decoder that compared the full word would miss the set.

A level input held high while software clears its bit must win over the clear. A design that gave the clear priority would lose the still-active condition.

Other checks cover the word and bit placement, write-0-does-nothing on the cause words, and a pending bit that is held while masked and must raise the line once unmasked. A reset in the middle of activity must restore the all-masked, nothing-pending state.

// File: rtl/eic_pkg.sv
package eic_pkg;
   localparam int unsigned EIC_STRIDE = 4;

   typedef enum logic [1:0] {
      ACC_NONE,
      ACC_CAUSE,
      ACC_MASK,
      ACC_DOOR
   } eic_acc_e;
endpackage

// File: rtl/eic_decode.sv
module eic_decode
   import eic_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_REGS   = 2,
   parameter int unsigned CAUSE_BASE = 'h00,
   parameter int unsigned MASK_BASE  = 'h20,
   parameter int unsigned DOOR_ADDR  = 'h30
) (
   input  logic [ADDR_W-1:0]          addr,
   input  logic                       we,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [NUM_REGS*DATA_W-1:0] cause_q,
   input  logic [NUM_REGS*DATA_W-1:0] mask_q,
   output logic [NUM_REGS*DATA_W-1:0] cause_clr,
   output logic [NUM_REGS-1:0]        mask_we,
   output logic                       door_we,
   output logic [DATA_W-1:0]          rdata
);
   localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   eic_acc_e          kind;
   logic [IDX_W-1:0]  widx;

   always_comb begin
      kind = ACC_NONE;
      widx = '0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (addr == ADDR_W'(CAUSE_BASE + r*EIC_STRIDE)) begin
            kind = ACC_CAUSE;
            widx = IDX_W'(r);
         end
         if (addr == ADDR_W'(MASK_BASE + r*EIC_STRIDE)) begin
            kind = ACC_MASK;
            widx = IDX_W'(r);
         end
      end
      if (addr == ADDR_W'(DOOR_ADDR)) kind = ACC_DOOR;
   end

   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_wr
         assign cause_clr[r*DATA_W +: DATA_W] =
            (we && kind == ACC_CAUSE && widx == IDX_W'(r)) ? wdata : '0;
         assign mask_we[r] = we && kind == ACC_MASK && widx == IDX_W'(r);
      end
   endgenerate

   assign door_we = we && kind == ACC_DOOR;

   always_comb begin
      rdata = '0;
      case (kind)
         ACC_CAUSE: rdata = cause_q[widx*DATA_W +: DATA_W];
         ACC_MASK:  rdata = mask_q[widx*DATA_W +: DATA_W];
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/eic_cause_bank.sv
module eic_cause_bank #(
   parameter int unsigned NUM_SRC   = 64,
   parameter int unsigned NUM_WIRED = 21,
   parameter int unsigned IDX_W     = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WIRED-1:0] wired_i,
   input  logic                 door_we,
   input  logic [IDX_W-1:0]     door_idx,
   input  logic [NUM_SRC-1:0]   clr,
   output logic [NUM_SRC-1:0]   cause_q
);
   logic [NUM_SRC-1:0] set_v;

   generate
      for (genvar n = 0; n < NUM_SRC; n++) begin : g_bit
         if (n < NUM_WIRED) begin : g_level
            assign set_v[n] = wired_i[n];
         end else begin : g_msg
            assign set_v[n] = door_we && (door_idx == IDX_W'(n));
         end

         always_ff @(posedge clk) begin
            if (!rst_n)         cause_q[n] <= 1'b0;
            else if (set_v[n])  cause_q[n] <= 1'b1;
            else if (clr[n])    cause_q[n] <= 1'b0;
         end

         // R7: a set in the same cycle as a clear leaves the bit pending
         a_r7_set_dominates: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[n] |=> cause_q[n]);
         // R3: a clear with no competing set empties the bit
         a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[n] && !set_v[n]) |=> !cause_q[n]);
         // R6: no bit becomes pending without its own set request
         a_r6_no_stray_set: assert property (@(posedge clk) disable iff (!rst_n)
            !set_v[n] |=> !$rose(cause_q[n]));
      end
   endgenerate
endmodule

// File: rtl/eic_mask_bank.sv
module eic_mask_bank #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_REGS-1:0]        we,
   input  logic [DATA_W-1:0]          wdata,
   output logic [NUM_REGS*DATA_W-1:0] mask_q
);
   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
         always_ff @(posedge clk) begin
            if (!rst_n)     mask_q[r*DATA_W +: DATA_W] <= '1;
            else if (we[r]) mask_q[r*DATA_W +: DATA_W] <= wdata;
         end

         // R4: a mask word changes only when it is written
         a_r4_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !we[r] |=> $stable(mask_q[r*DATA_W +: DATA_W]));
      end
   endgenerate
endmodule

// File: rtl/err_irq_collector.sv
module err_irq_collector #(
   parameter int unsigned NUM_SRC    = 64,
   parameter int unsigned NUM_WIRED  = 21,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned CAUSE_BASE = 'h00,
   parameter int unsigned MASK_BASE  = 'h20,
   parameter int unsigned DOOR_ADDR  = 'h30
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WIRED-1:0] wired_i,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   input  logic                 reg_we,
   output logic [DATA_W-1:0]    reg_rdata,
   output logic                 irq_o
);
   localparam int unsigned NUM_REGS = NUM_SRC / DATA_W;
   localparam int unsigned IDX_W    = $clog2(NUM_SRC);

   initial begin
      assert (NUM_SRC % DATA_W == 0)
         else $fatal(1, "source count must fill whole words");
      assert (NUM_WIRED > 0 && NUM_WIRED < NUM_SRC)
         else $fatal(1, "wired count out of range");
      assert (DOOR_ADDR < (1 << ADDR_W) && MASK_BASE < (1 << ADDR_W))
         else $fatal(1, "register offsets exceed address width");
      assert (IDX_W <= DATA_W)
         else $fatal(1, "index wider than data word");
   end

   logic [NUM_SRC-1:0]  cause_q;
   logic [NUM_SRC-1:0]  mask_q;
   logic [NUM_SRC-1:0]  cause_clr;
   logic [NUM_REGS-1:0] mask_we;
   logic                door_we;

   eic_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
      .CAUSE_BASE(CAUSE_BASE), .MASK_BASE(MASK_BASE), .DOOR_ADDR(DOOR_ADDR)
   ) u_dec (
      .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
      .cause_q(cause_q), .mask_q(mask_q),
      .cause_clr(cause_clr), .mask_we(mask_we), .door_we(door_we),
      .rdata(reg_rdata)
   );

   eic_cause_bank #(
      .NUM_SRC(NUM_SRC), .NUM_WIRED(NUM_WIRED), .IDX_W(IDX_W)
   ) u_cause (
      .clk(clk), .rst_n(rst_n), .wired_i(wired_i),
      .door_we(door_we), .door_idx(reg_wdata[IDX_W-1:0]),
      .clr(cause_clr), .cause_q(cause_q)
   );

   eic_mask_bank #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
   ) u_mask (
      .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(reg_wdata),
      .mask_q(mask_q)
   );

   assign irq_o = |(cause_q & ~mask_q);

   // R4: the summary line needs a pending bit behind it
   a_r4_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (cause_q != '0));
   // R4: with every source disabled the line stays low
   a_r4_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> !irq_o);
   // R1: the cycle after reset leaves nothing pending
   a_r1_reset_clean: assert property (@(posedge clk)
      !rst_n |=> (cause_q == '0 && (&mask_q)));
endmodule

// File: tb/sim_err_irq_collector.sv
module sim_err_irq_collector;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [20:0] wired_i = '0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_rdata;
   logic        irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   err_irq_collector u0 (
      .clk(clk), .rst_n(rst_n), .wired_i(wired_i),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
      .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   // {read, req, addr, data, irq}: read=1 compares rdata and irq, read=0 writes data
   localparam int NV = 26;
   localparam logic [45:0] VEC [0:NV-1] = '{
      {1'b1, 4'd1, 8'h00, 32'h0000_0000, 1'b0},   // R1 cause word 0
      {1'b1, 4'd1, 8'h04, 32'h0000_0000, 1'b0},   // R1 cause word 1
      {1'b1, 4'd1, 8'h20, 32'hFFFF_FFFF, 1'b0},   // R1 mask word 0
      {1'b1, 4'd1, 8'h24, 32'hFFFF_FFFF, 1'b0},   // R1 mask word 1
      {1'b0, 4'd5, 8'h30, 32'd21,        1'b0},
      {1'b1, 4'd5, 8'h00, 32'h0020_0000, 1'b0},   // R5 first message source
      {1'b0, 4'd2, 8'h30, 32'd63,        1'b0},
      {1'b1, 4'd2, 8'h04, 32'h8000_0000, 1'b0},   // R2 source 63 at word 1 bit 31
      {1'b0, 4'd5, 8'h30, 32'hABCD_0028, 1'b0},
      {1'b1, 4'd5, 8'h04, 32'h8000_0100, 1'b0},   // R5 upper data bits ignored
      {1'b0, 4'd6, 8'h30, 32'd5,         1'b0},
      {1'b1, 4'd6, 8'h00, 32'h0020_0000, 1'b0},   // R6 low index dropped
      {1'b0, 4'd8, 8'h20, 32'hFFDF_FFFF, 1'b0},
      {1'b1, 4'd8, 8'h20, 32'hFFDF_FFFF, 1'b1},   // R8 held event fires on unmask
      {1'b0, 4'd3, 8'h00, 32'h0000_0000, 1'b0},
      {1'b1, 4'd3, 8'h00, 32'h0020_0000, 1'b1},   // R3 writing 0 keeps bit
      {1'b0, 4'd3, 8'h00, 32'h0020_0000, 1'b0},
      {1'b1, 4'd3, 8'h00, 32'h0000_0000, 1'b0},   // R3 writing 1 clears
      {1'b0, 4'd3, 8'h04, 32'h0000_0100, 1'b0},
      {1'b1, 4'd3, 8'h04, 32'h8000_0000, 1'b0},   // R3 only the named bit clears
      {1'b0, 4'd4, 8'h24, 32'h7FFF_FFFF, 1'b0},
      {1'b1, 4'd4, 8'h24, 32'h7FFF_FFFF, 1'b1},   // R4 enable source 63
      {1'b0, 4'd3, 8'h04, 32'h8000_0000, 1'b0},
      {1'b1, 4'd3, 8'h04, 32'h0000_0000, 1'b0},   // R3 cleared, line drops
      {1'b1, 4'd2, 8'h30, 32'h0000_0000, 1'b0},   // R2 doorbell reads 0
      {1'b1, 4'd2, 8'h10, 32'h0000_0000, 1'b0}    // R2 unmapped reads 0
   };

   task automatic chk(input int req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int req, input logic [7:0] a,
                     input logic [31:0] exp_d, input logic exp_irq);
      reg_addr = a;
      #1;
      chk(req, "rdata", reg_rdata, exp_d);
      chk(req, "irq", {31'd0, irq_o}, {31'd0, exp_irq});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][45]) rd(int'(VEC[i][44:41]), VEC[i][40:33], VEC[i][32:1], VEC[i][0]);
         else            wr(VEC[i][40:33], VEC[i][32:1]);
      end

      // R7: a level input latches and survives a clear while still high
      @(negedge clk);
      wired_i[3] = 1'b1;
      @(negedge clk);
      rd(7, 8'h00, 32'h0000_0008, 1'b0);
      wr(8'h00, 32'h0000_0008);
      rd(7, 8'h00, 32'h0000_0008, 1'b0);
      wired_i[3] = 1'b0;
      @(negedge clk);
      rd(7, 8'h00, 32'h0000_0008, 1'b0);
      wr(8'h00, 32'h0000_0008);
      rd(7, 8'h00, 32'h0000_0000, 1'b0);

      // R7 / R4: short pulse on the top wired source, then unmask it
      wired_i[20] = 1'b1;
      @(negedge clk);
      wired_i[20] = 1'b0;
      @(negedge clk);
      rd(7, 8'h00, 32'h0010_0000, 1'b0);
      wr(8'h20, 32'hFFEF_FFFF);
      rd(4, 8'h20, 32'hFFEF_FFFF, 1'b1);

      // R1: reset in mid-run restores the idle state
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rd(1, 8'h00, 32'h0000_0000, 1'b0);
      rd(1, 8'h20, 32'hFFFF_FFFF, 1'b0);
      rd(1, 8'h04, 32'h0000_0000, 1'b0);
      rst_n = 1'b1;

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule